// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block steers the level-sensitive interrupt pins of PCI devices onto a 16-line legacy IRQ vector. Each device request carries a device number, an interrupt pin (1 = INTA through 4 = INTD) and an assert or deassert flag. The pin index is rotated by the device number to pick one of four shared route registers. That register names the target IRQ and carries a disable flag.

A byte-wide configuration port reads and writes the four route registers. The same port returns the fixed reset image of the bridge's command and status words. The block records which device/pin sources are currently asserting. Each route's line stays high while at least one of its sources is active. The IRQ vector is derived combinationally from that record and from the route registers, so an update becomes visible right after the clock edge that stores it.

Top module: `pci_irq_router`

## Requirements
- R1: After reset, all four route registers read 0x80 and `irq_out` is all zeros.
- R2: Route registers for routes 0..3 sit at offsets 0x60..0x63. Bit 7 (disable) and bits 3:0 (IRQ number) are writable. Bits 6:4 read 0 and ignore writes.
- R3: Offsets 0x04 and 0x05 read the command word 0x0007 (low byte first). Offsets 0x06 and 0x07 read the status word 0x0200 (low byte first). Writes there have no effect.
- R4: A request from device d on pin p (1..4) uses route ((p-1)+(d-1)) mod 4. Device 0 counts as d-1 = 3 mod 4.
- R5: An assert request sets the output bit numbered by the chosen route's IRQ field. A deassert request from the same source clears it.
- R6: While bit 7 of a route is 1, that route drives no output bit. Its IRQ field is still written and read back.
- R7: When several sources share a route, its IRQ bit stays set until the last of them deasserts.
- R8: IRQ numbers 0, 1, 2, 8 and 13 drive no output bit. Any other value 3..15 does.
- R9: Rewriting the IRQ field of an active route moves the set bit from the old number to the new one at the same clock edge that stores the write.
- R10: A request with pin 0 or pin 5..7 changes nothing: it neither sets nor clears any source.
- R11: Any configuration offset other than those in R2 and R3 reads 0, and writes there are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| req_valid | input | 1 | Interrupt request strobe |
| req_dev | input | 3 | Requesting device number |
| req_pin | input | 3 | Interrupt pin, 1..4 valid |
| req_assert | input | 1 | 1 = assert, 0 = deassert |
| irq_out | output | 16 | Legacy IRQ line vector |

## Verification
A route-register write and an interrupt request can land in the same clock. The write changes where a source is steered, and the request changes whether that source is active. The bench provokes this by driving a rewrite of route 0 and an assert from a source mapped to route 0 in one cycle. After that edge, `irq_out` must show exactly the newly written IRQ bit, with no trace of the old number. The route-move case (R9) is the converse: the source is already active when the write arrives, and the bit must move within one edge.

// File: rtl/pir_pkg.sv
`timescale 1ns/1ps
package pir_pkg;
  localparam int unsigned ROUTES   = 4;
  localparam int unsigned PINS     = 4;
  localparam int unsigned IRQ_W    = 16;
  localparam int unsigned ROUTE_IW = $clog2(ROUTES);

  localparam logic [7:0]  ROUTE_BASE = 8'h60;
  localparam logic [7:0]  ROUTE_RST  = 8'h80;
  localparam logic [7:0]  CMD_OFF    = 8'h04;
  localparam logic [7:0]  STS_OFF    = 8'h06;
  localparam logic [15:0] CMD_RST    = 16'h0007;
  localparam logic [15:0] STS_RST    = 16'h0200;
  localparam logic [15:0] BAD_IRQS   = 16'h2107;

  typedef struct packed {
    logic       dis;
    logic [3:0] irq;
  } route_t;

  function automatic logic irq_usable(input logic [3:0] n);
    return BAD_IRQS[n] == 1'b0;
  endfunction

  // rotate pin by device number: ((pin-1)+(dev-1)) mod 4
  function automatic logic [ROUTE_IW-1:0] route_idx(input logic [1:0] pin_m1,
                                                    input logic [1:0] dev_lo);
    return pin_m1 + dev_lo - 2'd1;
  endfunction
endpackage

// File: rtl/pir_cfg_regs.sv
`timescale 1ns/1ps
module pir_cfg_regs
  import pir_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [7:0]                wdata,
  output logic [7:0]                rdata,
  output route_t [ROUTES-1:0]       routes_o
);
  route_t [ROUTES-1:0] routes_q, routes_d;
  logic                route_hit;
  logic [ROUTE_IW-1:0] route_sel;

  assign route_hit = (addr[ADDR_W-1:ROUTE_IW] == ROUTE_BASE[ADDR_W-1:ROUTE_IW]);
  assign route_sel = addr[ROUTE_IW-1:0];

  always_comb begin
    routes_d = routes_q;
    if (wr_en && route_hit) begin
      routes_d[route_sel].dis = wdata[7];
      routes_d[route_sel].irq = wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROUTES; r++) begin
        routes_q[r].dis <= ROUTE_RST[7];
        routes_q[r].irq <= ROUTE_RST[3:0];
      end
    end else if (wr_en) begin
      routes_q <= routes_d;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (route_hit)                  rdata = {routes_q[route_sel].dis, 3'b000, routes_q[route_sel].irq};
    else if (addr == CMD_OFF)       rdata = CMD_RST[7:0];
    else if (addr == CMD_OFF + 8'd1) rdata = CMD_RST[15:8];
    else if (addr == STS_OFF)       rdata = STS_RST[7:0];
    else if (addr == STS_OFF + 8'd1) rdata = STS_RST[15:8];
  end

  assign routes_o = routes_q;

  // R2 R6
  route_field_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && route_hit) |=> (routes_q[$past(route_sel)].irq == $past(wdata[3:0])
                              && routes_q[$past(route_sel)].dis == $past(wdata[7])));
endmodule

// File: rtl/pir_src_tracker.sv
`timescale 1ns/1ps
module pir_src_tracker
  import pir_pkg::*;
#(
  parameter int unsigned NUM_DEV = 8,
  localparam int unsigned DEV_W  = $clog2(NUM_DEV),
  localparam int unsigned SRC_N  = NUM_DEV * PINS,
  localparam int unsigned SRC_W  = $clog2(SRC_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [DEV_W-1:0] req_dev,
  input  logic [2:0]       req_pin,
  input  logic             req_assert,
  output logic [SRC_N-1:0] pending_o
);
  logic [SRC_N-1:0] pending_q, pending_d;
  logic             pin_ok;
  logic [1:0]       pin_m1;
  logic [SRC_W-1:0] src;

  assign pin_ok = (req_pin != 3'd0) && (req_pin <= 3'(PINS));
  assign pin_m1 = 2'(req_pin - 3'd1);
  assign src    = {req_dev, pin_m1};

  always_comb begin
    pending_d = pending_q;
    if (req_valid && pin_ok) pending_d[src] = req_assert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pending_q <= '0;
    else if (req_valid) pending_q <= pending_d;
  end

  assign pending_o = pending_q;

  // R5
  deassert_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pin_ok && !req_assert) |=> !pending_q[$past(src)]);

  // R10
  bad_pin_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pin_ok) |=> (pending_q == $past(pending_q)));
endmodule

// File: rtl/pir_irq_merge.sv
`timescale 1ns/1ps
module pir_irq_merge
  import pir_pkg::*;
#(
  parameter int unsigned SRC_N = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SRC_N-1:0]    pending_i,
  input  route_t [ROUTES-1:0] routes_i,
  output logic [IRQ_W-1:0]    irq_o
);
  logic [ROUTES-1:0] level;
  logic [ROUTES-1:0] drive;

  // wired-OR of every source steered to each route
  always_comb begin
    level = '0;
    for (int s = 0; s < SRC_N; s++) begin
      if (pending_i[s]) level[route_idx(2'(s), 2'(s >> 2))] = 1'b1;
    end
  end

  for (genvar r = 0; r < ROUTES; r++) begin : g_route
    assign drive[r] = level[r] && !routes_i[r].dis && irq_usable(routes_i[r].irq);
  end

  always_comb begin
    irq_o = '0;
    for (int r = 0; r < ROUTES; r++) begin
      if (drive[r]) irq_o[routes_i[r].irq] = 1'b1;
    end
  end

  // R8
  no_reserved_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & BAD_IRQS) == '0);

  // R7
  line_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_o) <= ROUTES);

  // R5
  line_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> (|pending_i));
endmodule

// File: rtl/pci_irq_router.sv
`timescale 1ns/1ps
module pci_irq_router
  import pir_pkg::*;
#(
  parameter int unsigned NUM_DEV = 8,
  localparam int unsigned DEV_W  = $clog2(NUM_DEV),
  localparam int unsigned SRC_N  = NUM_DEV * PINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic             req_valid,
  input  logic [DEV_W-1:0] req_dev,
  input  logic [2:0]       req_pin,
  input  logic             req_assert,
  output logic [IRQ_W-1:0] irq_out
);
  route_t [ROUTES-1:0] routes;
  logic [SRC_N-1:0]    pending;

  pir_cfg_regs #(.ADDR_W(8)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .routes_o (routes)
  );

  pir_src_tracker #(.NUM_DEV(NUM_DEV)) u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_dev    (req_dev),
    .req_pin    (req_pin),
    .req_assert (req_assert),
    .pending_o  (pending)
  );

  pir_irq_merge #(.SRC_N(SRC_N)) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending_i (pending),
    .routes_i  (routes),
    .irq_o     (irq_out)
  );

  // R6
  disabled_route_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (routes[0].dis && routes[1].dis && routes[2].dis && routes[3].dis) |-> (irq_out == '0));
endmodule

// File: tb/pci_irq_router_tb.sv
`timescale 1ns/1ps
module pci_irq_router_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [7:0]  cfg_addr, cfg_wdata, cfg_rdata;
  logic        req_valid, req_assert;
  logic [2:0]  req_dev, req_pin;
  logic [15:0] irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pci_irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_dev(req_dev), .req_pin(req_pin), .req_assert(req_assert), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int route_of(input int dev, input int pin);
    return ((pin - 1) + (dev - 1) + 8) % 4;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 check(tag, 32'(cfg_rdata), 32'(exp));
  endtask

  task automatic req(input int dev, input int pin, input bit as);
    @(negedge clk);
    req_dev = 3'(dev); req_pin = 3'(pin); req_assert = as; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic out_chk(input string tag, input logic [15:0] exp);
    @(negedge clk);
    check(tag, 32'(irq_out), 32'(exp));
  endtask

  task automatic t_reset();
    for (int r = 0; r < 4; r++) rd_chk("R1 route reset", 8'(8'h60 + r), 8'h80);
    out_chk("R1 irq_out reset", 16'h0);
  endtask

  task automatic t_regs();
    wr(8'h60, 8'hF5); rd_chk("R2 reserved bits dropped", 8'h60, 8'h85);
    wr(8'h63, 8'h0A); rd_chk("R2 route 3 write", 8'h63, 8'h0A);
    rd_chk("R2 route 1 untouched", 8'h61, 8'h80);
  endtask

  task automatic t_hdr();
    rd_chk("R3 command lo", 8'h04, 8'h07);
    rd_chk("R3 command hi", 8'h05, 8'h00);
    rd_chk("R3 status lo",  8'h06, 8'h00);
    rd_chk("R3 status hi",  8'h07, 8'h02);
    wr(8'h04, 8'h00); rd_chk("R3 command write ignored", 8'h04, 8'h07);
    wr(8'h07, 8'hFF); rd_chk("R3 status write ignored", 8'h07, 8'h02);
  endtask

  task automatic t_unmapped();
    wr(8'h64, 8'h55); rd_chk("R11 offset 0x64 reads 0", 8'h64, 8'h00);
    wr(8'h5F, 8'h55); rd_chk("R11 offset 0x5f reads 0", 8'h5F, 8'h00);
    rd_chk("R11 route 0 unaffected", 8'h60, 8'h85);
    rd_chk("R11 route 3 unaffected", 8'h63, 8'h0A);
  endtask

  task automatic t_swizzle();
    logic [3:0] tgt [4] = '{4'd3, 4'd4, 4'd5, 4'd6};
    for (int r = 0; r < 4; r++) wr(8'(8'h60 + r), {4'h0, tgt[r]});
    for (int d = 0; d < 8; d++) begin
      for (int p = 1; p <= 4; p++) begin
        req(d, p, 1'b1);
        out_chk($sformatf("R4 R5 assert dev %0d pin %0d", d, p), 16'(1) << tgt[route_of(d, p)]);
        req(d, p, 1'b0);
        out_chk($sformatf("R5 deassert dev %0d pin %0d", d, p), 16'h0);
      end
    end
  endtask

  task automatic t_disable();
    wr(8'h60, 8'h87);
    req(1, 1, 1'b1);
    out_chk("R6 disabled route quiet", 16'h0);
    rd_chk("R6 irq field still written", 8'h60, 8'h87);
    wr(8'h60, 8'h07);
    out_chk("R6 enabled route drives", 16'h0080);
    req(1, 1, 1'b0);
    out_chk("R6 released", 16'h0);
  endtask

  task automatic t_shared();
    wr(8'h61, 8'h09);
    req(1, 2, 1'b1);
    req(2, 1, 1'b1);
    out_chk("R7 two sources", 16'h0200);
    req(1, 2, 1'b0);
    out_chk("R7 one source left", 16'h0200);
    req(2, 1, 1'b0);
    out_chk("R7 last source gone", 16'h0);
  endtask

  task automatic t_badirq();
    logic [3:0] bad [5] = '{4'd0, 4'd1, 4'd2, 4'd8, 4'd13};
    for (int i = 0; i < 5; i++) begin
      wr(8'h62, {4'h0, bad[i]});
      req(1, 3, 1'b1);
      out_chk($sformatf("R8 irq %0d blocked", bad[i]), 16'h0);
      req(1, 3, 1'b0);
    end
    wr(8'h62, 8'h0F);
    req(1, 3, 1'b1);
    out_chk("R8 irq 15 usable", 16'h8000);
    req(1, 3, 1'b0);
  endtask

  task automatic t_move();
    wr(8'h63, 8'h0B);
    req(1, 4, 1'b1);
    out_chk("R9 before move", 16'h0800);
    wr(8'h63, 8'h0C);
    check("R9 moved at write edge", 32'(irq_out), 32'h1000);
    req(1, 4, 1'b0);
    out_chk("R9 released", 16'h0);
  endtask

  task automatic t_badpin();
    wr(8'h60, 8'h03);
    req(1, 0, 1'b1); req(1, 5, 1'b1); req(1, 7, 1'b1);
    out_chk("R10 bad pins set nothing", 16'h0);
    req(1, 1, 1'b1);
    req(1, 6, 1'b0);
    out_chk("R10 bad pin deassert ignored", 16'h0008);
    req(1, 1, 1'b0);
    out_chk("R10 proper release", 16'h0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    cfg_addr = 8'h60; cfg_wdata = 8'h0E; cfg_wr = 1'b1;
    req_dev = 3'd1; req_pin = 3'd1; req_assert = 1'b1; req_valid = 1'b1;
    @(posedge clk); #1;
    cfg_wr = 1'b0; req_valid = 1'b0;
    check("R5 R9 write and assert same cycle", 32'(irq_out), 32'h4000);
    req(1, 1, 1'b0);
    out_chk("R5 same-cycle release", 16'h0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_dev = '0; req_pin = '0; req_assert = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_regs();
    t_hdr();
    t_unmapped();
    t_swizzle();
    t_disable();
    t_shared();
    t_badirq();
    t_move();
    t_badpin();
    t_same_cycle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule